// File: doc/BRIEF.md
# Upper Memory Shadow Routing Unit

This block is the configuration unit of a legacy PC chipset. Software reaches a bank of 256 byte-wide registers through two I/O ports. One port latches a register number. The other port reads or writes the register that the latched number selects. Three of these registers set how the upper memory area from C0000h to FFFFFh is routed. Each window of that area can send its reads and its writes either to internal shadow DRAM or out to the external bus.

For any memory address, the route decoder gives two outputs. One tells whether a read at that address is served internally. The other tells whether a write at that address lands internally. The C and D segments are cut into 16 KB windows, and each window has its own read bit and write bit. The E and F segments are each steered as a single 64 KB block. The unit also drives a level that enables the external cache, and it raises a one-cycle strobe telling the CPU timing logic to refresh its wait states.

The I/O accesses are single-cycle strobes, so no valid/ready handshake applies. A write request is accepted on every clock edge where its strobe is high. The route outputs depend only on the present address and the stored registers, with no added latency.

Top module: `shadow_cfg_unit`

## Requirements
- R1: An I/O write to address 8022h stores the data byte as the current register number. An I/O write to 8024h stores the data byte into the register with that number. A later I/O read of 8024h returns the stored byte.
- R2: `io_rdata` is FFh for a read of any address other than 8024h, including 8022h, and whenever `io_rd` is low.
- R3: All 256 register numbers hold plain byte storage. Each reads back the last value written to it.
- R4: Register CDh steers the C segment in 16 KB windows. Bits 7 (write) and 6 (read) control C0000h, bits 5/4 control C4000h, bits 3/2 control C8000h, and bits 1/0 control CC000h.
- R5: Register CEh steers the D segment with the same layout: D0000h uses bits 7/6, D4000h uses 5/4, D8000h uses 3/2, and DC000h uses 1/0 (write/read).
- R6: In register CCh, bit 4 (read) and bit 5 (write) steer the whole E segment, E0000h to EFFFFh.
- R7: In register CCh, bit 6 (read) and bit 7 (write) steer the whole F segment, F0000h to FFFFFh.
- R8: Any address below C0000h is routed externally for both directions: `rd_internal` and `wr_internal` are both 0.
- R9: A synchronous active-low reset clears the register number and all 256 registers to 00h. After reset, all upper memory routes externally, `ext_cache_en` is 0 and `ws_update` is 0.
- R10: `ext_cache_en` equals bit 0 of the value last written to register D1h. Writes to other registers leave it unchanged.
- R11: A write to register D0h drives `ws_update` high for exactly the following clock cycle. Writes to other registers do not raise it.
- R12: A route decode made in the same cycle as a register write uses the old register value. The new routing appears from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one access per high cycle |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 20 | Memory address being decoded |
| rd_internal | output | 1 | 1: a read at mem_addr goes to shadow DRAM |
| wr_internal | output | 1 | 1: a write at mem_addr goes to shadow DRAM |
| ext_cache_en | output | 1 | External cache enable |
| ws_update | output | 1 | One-cycle wait-state refresh strobe |

## Verification
The bench sweeps all 64 16 KB pages under several register patterns, with the read and write bits set to differ. A decoder that swapped the two bits of a pair, or reversed the window order inside a segment, would therefore route the wrong window or the wrong direction. Reads of the index port and idle reads are checked for FFh. This catches a design that echoes the register number back or leaks stale data. The bench probes the decode in the very cycle of a CDh write and again one cycle later, so a design that bypassed the new value early, or that lagged by an extra cycle, is caught. Back-to-back writes to D0h and D1h, and writes to neighbouring registers, show whether the strobe is a true single pulse and whether the cache enable moves only on its own register.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  localparam logic [7:0] EF_CTL_IDX = 8'hCC;
  localparam logic [7:0] C_CTL_IDX  = 8'hCD;
  localparam logic [7:0] D_CTL_IDX  = 8'hCE;
  localparam logic [7:0] WS_IDX     = 8'hD0;
  localparam logic [7:0] CACHE_IDX  = 8'hD1;

  typedef struct packed {
    logic [7:0] ef_ctl;
    logic [7:0] c_ctl;
    logic [7:0] d_ctl;
  } shadow_cfg_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_cfg_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          NREG     = 256,
  parameter logic [15:0] IDX_PORT = 16'h8022,
  parameter logic [15:0] DAT_PORT = 16'h8024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output shadow_cfg_t   cfg,
  output logic          cache_en,
  output logic          ws_pulse
);
  localparam int IW = $clog2(NREG);

  logic [IW-1:0] index_q;
  logic [DW-1:0] store [NREG];
  logic          idx_wr, dat_wr, dat_rd;

  assign idx_wr = io_wr && (io_addr == AW'(IDX_PORT));
  assign dat_wr = io_wr && (io_addr == AW'(DAT_PORT));
  assign dat_rd = io_rd && (io_addr == AW'(DAT_PORT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q  <= '0;
      ws_pulse <= 1'b0;
      for (int k = 0; k < NREG; k++) store[k] <= '0;
    end else begin
      ws_pulse <= dat_wr && (index_q == IW'(WS_IDX));
      if (idx_wr) index_q <= io_wdata[IW-1:0];
      if (dat_wr) store[index_q] <= io_wdata;
    end
  end

  assign io_rdata     = dat_rd ? store[index_q] : {DW{1'b1}};
  assign cfg.ef_ctl   = store[IW'(EF_CTL_IDX)];
  assign cfg.c_ctl    = store[IW'(C_CTL_IDX)];
  assign cfg.d_ctl    = store[IW'(D_CTL_IDX)];
  assign cache_en     = store[IW'(CACHE_IDX)][0];

  // R1: the register number follows the last index-port write
  a_r1_index_capture: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (index_q == $past(io_wdata[IW-1:0])));

  // R11: the strobe only follows a data write while D0h is selected
  a_r11_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    ws_pulse |-> $past(dat_wr && (index_q == IW'(WS_IDX))));

  // R10: the cache enable moves only after a write to D1h
  a_r10_cache_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_en != $past(cache_en)) |-> $past(dat_wr && (index_q == IW'(CACHE_IDX))));

  // R9: the cycle after reset, routing and outputs are cleared
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (cfg == '0 && !cache_en && !ws_pulse && index_q == '0));
endmodule

// File: rtl/shadow_route_decode.sv
module shadow_route_decode
  import shadow_cfg_pkg::*;
#(
  parameter int ABITS    = 20,
  parameter int WIN_BITS = 14
) (
  input  logic [ABITS-1:0] mem_addr,
  input  shadow_cfg_t      cfg,
  output logic             rd_internal,
  output logic             wr_internal
);
  localparam int PW          = ABITS - WIN_BITS;   // page number width
  localparam int WIN_PER_SEG = 1 << (16 - WIN_BITS);
  localparam int NSEG        = 4;                  // C, D, E, F
  localparam int SPLIT_SEGS  = 2;                  // C and D use windows
  localparam int NWIN        = NSEG * WIN_PER_SEG;
  localparam int WW          = $clog2(NWIN);
  localparam int UMA_BASE    = (1 << PW) - NWIN;

  logic [PW-1:0]   page;
  logic [WW-1:0]   win;
  logic            in_uma;
  logic [NWIN-1:0] rd_vec, wr_vec;

  assign page   = mem_addr[ABITS-1:WIN_BITS];
  assign in_uma = (page >= PW'(UMA_BASE));
  assign win    = WW'(page - PW'(UMA_BASE));

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int SEG = w / WIN_PER_SEG;
    localparam int SUB = w % WIN_PER_SEG;
    if (SEG < SPLIT_SEGS) begin : g_split
      localparam int RB = 2 * (WIN_PER_SEG - 1 - SUB);
      assign rd_vec[w] = (SEG == 0) ? cfg.c_ctl[RB]   : cfg.d_ctl[RB];
      assign wr_vec[w] = (SEG == 0) ? cfg.c_ctl[RB+1] : cfg.d_ctl[RB+1];
    end else begin : g_whole
      localparam int RB = 4 + 2 * (SEG - SPLIT_SEGS);
      assign rd_vec[w] = cfg.ef_ctl[RB];
      assign wr_vec[w] = cfg.ef_ctl[RB+1];
    end
  end

  assign rd_internal = in_uma && rd_vec[win];
  assign wr_internal = in_uma && wr_vec[win];

  // R8: conventional and low memory never routes internally
  always_comb begin
    if (mem_addr[ABITS-1:ABITS-2] != 2'b11)
      a_r8_low_external: assert (!rd_internal && !wr_internal);
  end
endmodule

// File: rtl/shadow_cfg_unit.sv
module shadow_cfg_unit
  import shadow_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [19:0] mem_addr,
  output logic        rd_internal,
  output logic        wr_internal,
  output logic        ext_cache_en,
  output logic        ws_update
);
  shadow_cfg_t cfg;

  shadow_cfg_regs #(
    .AW(16), .DW(8), .NREG(256), .IDX_PORT(16'h8022), .DAT_PORT(16'h8024)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .cfg      (cfg),
    .cache_en (ext_cache_en),
    .ws_pulse (ws_update)
  );

  shadow_route_decode #(.ABITS(20), .WIN_BITS(14)) u_route (
    .mem_addr    (mem_addr),
    .cfg         (cfg),
    .rd_internal (rd_internal),
    .wr_internal (wr_internal)
  );
endmodule

// File: tb/test_shadow_cfg_unit.sv
module test_shadow_cfg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = 20'h0;
  logic        rd_internal, wr_internal, ext_cache_en, ws_update;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shadow_cfg_unit i_shadow_cfg_unit (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    io_write(16'h8022, idx);
    io_write(16'h8024, d);
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1; io_addr = a; #1; d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    io_write(16'h8022, idx);
    io_read(16'h8024, d);
  endtask

  // {write, read} routing from the requirements
  function automatic logic [1:0] exp_route(input logic [7:0] ef, cc, dd, input logic [19:0] a);
    logic [7:0] r;
    int sh;
    if (a < 20'hC0000) return 2'b00;
    case (a[17:16])
      2'b10: return {ef[5], ef[4]};
      2'b11: return {ef[7], ef[6]};
      default: begin
        r  = a[16] ? dd : cc;
        sh = 6 - 2 * int'(a[15:14]);
        return {r[sh+1], r[sh]};
      end
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic sweep(input logic [7:0] ef, cc, dd, input string tag);
    logic [1:0] e;
    reg_write(8'hCC, ef); reg_write(8'hCD, cc); reg_write(8'hCE, dd);
    for (int p = 0; p < 64; p++) begin
      mem_addr = {p[5:0], 14'h1A5};
      #1;
      e = exp_route(ef, cc, dd, mem_addr);
      chk({wr_internal, rd_internal} == e, tag, {wr_internal, rd_internal}, e);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    #1;
    chk(ext_cache_en == 0, "R9 cache", ext_cache_en, 0);
    chk(ws_update == 0, "R9 strobe", ws_update, 0);
    io_read(16'h8024, d);      // index is 00h after reset
    chk(d == 8'h00, "R9 index0", d, 0);
    for (int p = 48; p < 64; p++) begin
      mem_addr = {p[5:0], 14'h0}; #1;
      chk(!rd_internal && !wr_internal, "R9 route", {wr_internal, rd_internal}, 0);
    end
    reg_read(8'hCD, d); chk(d == 0, "R9 CD", d, 0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    reg_write(8'h42, 8'hA7);
    io_read(16'h8024, d); chk(d == 8'hA7, "R1 readback", d, 8'hA7);
    io_read(16'h8022, d); chk(d == 8'hFF, "R2 index port", d, 8'hFF);
    io_read(16'h8023, d); chk(d == 8'hFF, "R2 other port", d, 8'hFF);
    @(negedge clk); io_addr = 16'h8024; #1;
    chk(io_rdata == 8'hFF, "R2 idle", io_rdata, 8'hFF);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    for (int i = 0; i < 256; i++) reg_write(i[7:0], i[7:0] ^ 8'h5A);
    for (int i = 0; i < 256; i++) begin
      reg_read(i[7:0], d);
      chk(d == (i[7:0] ^ 8'h5A), "R3 storage", d, i[7:0] ^ 8'h5A);
    end
    do_reset();
  endtask

  task automatic t_routes();
    sweep(8'h00, 8'h9C, 8'h00, "R4 C windows");
    sweep(8'h00, 8'h63, 8'h00, "R4 C windows alt");
    sweep(8'h00, 8'h00, 8'hC6, "R5 D windows");
    sweep(8'h00, 8'h00, 8'h39, "R5 D windows alt");
    sweep(8'h10, 8'h00, 8'h00, "R6 E read");
    sweep(8'h20, 8'h00, 8'h00, "R6 E write");
    sweep(8'h40, 8'h00, 8'h00, "R7 F read");
    sweep(8'h8F, 8'h00, 8'h00, "R7 F write");
    sweep(8'hFF, 8'hFF, 8'hFF, "R8 all set");
  endtask

  task automatic t_cache();
    reg_write(8'hD1, 8'h01); #1; chk(ext_cache_en == 1, "R10 on", ext_cache_en, 1);
    reg_write(8'hD2, 8'h00); #1; chk(ext_cache_en == 1, "R10 neighbour", ext_cache_en, 1);
    reg_write(8'hD0, 8'h00); #1; chk(ext_cache_en == 1, "R10 D0", ext_cache_en, 1);
    reg_write(8'hD1, 8'hFE); #1; chk(ext_cache_en == 0, "R10 off", ext_cache_en, 0);
  endtask

  task automatic t_strobe();
    io_write(16'h8022, 8'hD0);
    @(negedge clk); io_wr = 1; io_addr = 16'h8024; io_wdata = 8'h3;
    @(negedge clk); io_wr = 0; #1;
    chk(ws_update == 1, "R11 high", ws_update, 1);
    @(negedge clk); #1;
    chk(ws_update == 0, "R11 single", ws_update, 0);
    reg_write(8'hD1, 8'h00);
    @(negedge clk); #1; chk(ws_update == 0, "R11 other reg", ws_update, 0);
  endtask

  task automatic t_same_cycle();
    reg_write(8'hCD, 8'h00);
    io_write(16'h8022, 8'hCD);
    @(negedge clk); io_wr = 1; io_addr = 16'h8024; io_wdata = 8'hFF;
    mem_addr = 20'hC0000; #1;
    chk(rd_internal == 0, "R12 old value", rd_internal, 0);
    @(negedge clk); io_wr = 0; #1;
    chk(rd_internal == 1 && wr_internal == 1, "R12 new value", {wr_internal, rd_internal}, 3);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ports();
    t_storage();
    t_routes();
    t_cache();
    t_strobe();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule